// File: doc/BRIEF.md
# Timer Clock Source Selector and Prescaler

This block produces the count-enable pulse for a general-purpose timer's counter. A 3-bit slave mode code decides where prescaler input events come from. In some codes every cycle of the timer's own clock is an event. In the other codes the event source is one of eight lines, picked by a 3-bit trigger select code. A picked line supplies one event for each rising edge, sampled in the timer clock domain.

A 16-bit divide value sets how many input events make up one output tick. The output is a single-cycle enable pulse that the timer counter uses to advance. The divide value is held in a shadow register, so a new value is used only at the next wrap. Clearing the counter-enable input stops ticks and clears the prescaler count.

Top module: `tmr_clk_presc`

## Requirements
- R1: After reset, `tick_o` is 0 and the prescaler count is 0. While `cnt_en_i` is 0, no tick is produced.
- R2: When `slv_mode_i` is 0, 4, 5 or 6, every clock cycle with `cnt_en_i` high is one prescaler event. Activity on the eight source lines has no effect on the tick output in these modes.
- R3: When `slv_mode_i` is 1, 2, 3 or 7, prescaler events come only from the source line chosen by `trig_sel_i`.
- R4: The `trig_sel_i` codes map to sources as follows. Codes 0 to 3 pick `itrig_i[0]` to `itrig_i[3]`. Code 4 picks `ch0_edge_i`. Code 5 picks `ch_filt_i[0]`. Code 6 picks `ch_filt_i[1]`. Code 7 picks `ext_trig_i`.
- R5: A chosen line produces one event per low-to-high transition seen at the clock. Holding the line high gives no further events. Lines that are not chosen are ignored.
- R6: With divide value P, one tick is produced per P+1 events. `tick_o` goes high for one clock cycle, in the cycle after the event that completes the period.
- R7: A divide value changed while counting takes effect only after the current period completes. The period in progress is neither shortened nor lengthened.
- R8: Clearing `cnt_en_i` returns the prescaler count to 0. After re-enabling, a full P+1 events are needed before the next tick.
- R9: A divide value applied while `cnt_en_i` is 0 governs the first period after enabling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Internal timer clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| slv_mode_i | input | 3 | Slave mode code |
| trig_sel_i | input | 3 | Trigger source select code |
| itrig_i | input | 4 | Internal trigger inputs 0 to 3 |
| ch0_edge_i | input | 1 | Edge-detected channel 0 input |
| ch_filt_i | input | 2 | Filtered timer input channels 0 and 1 |
| ext_trig_i | input | 1 | Filtered external trigger |
| cnt_en_i | input | 1 | Counter enable |
| psc_val_i | input | 16 | Prescaler divide value (ratio is value + 1) |
| tick_o | output | 1 | Single-cycle prescaled tick enable |

## Verification
A corrupted prescaler count or shadow ratio shows up as a changed number of ticks. Each count window covers at most a few periods, so the error shows within one period of P+1 events. Wrong mode decoding or a wrong source mapping changes the tick count within the first period of a case: either noise on unselected lines is counted, or the selected line is ignored. A stale edge sample gives extra or missing events while the line is held high, and the long-high pulses in the external-mode cases expose it.

// File: rtl/tmr_presc_pkg.sv
package tmr_presc_pkg;

    localparam int unsigned MODE_W = 3;
    localparam int unsigned SEL_W  = 3;
    localparam int unsigned NSRC   = 1 << SEL_W;

    // Slave mode codes that route a trigger-selected source to the prescaler
    function automatic logic mode_uses_src(input logic [MODE_W-1:0] mode);
        logic r;
        case (mode)
            3'd1, 3'd2, 3'd3, 3'd7: r = 1'b1;
            default:                r = 1'b0;
        endcase
        return r;
    endfunction

    typedef struct packed {
        logic prev;
    } edge_state_t;

endpackage

// File: rtl/tmr_src_sel.sv
module tmr_src_sel
    import tmr_presc_pkg::*;
#(
    parameter int unsigned NITRIG = 4
) (
    input  logic [MODE_W-1:0] slv_mode_i,
    input  logic [SEL_W-1:0]  trig_sel_i,
    input  logic [NITRIG-1:0] itrig_i,
    input  logic              ch0_edge_i,
    input  logic [1:0]        ch_filt_i,
    input  logic              ext_trig_i,
    output logic              use_src_o,
    output logic              src_lvl_o
);
    logic [NSRC-1:0] src_vec;

    // Source vector ordered by select code
    genvar gi;
    generate
        for (gi = 0; gi < NITRIG; gi++) begin : g_itrig
            assign src_vec[gi] = itrig_i[gi];
        end
    endgenerate

    assign src_vec[NITRIG]   = ch0_edge_i;
    assign src_vec[NITRIG+1] = ch_filt_i[0];
    assign src_vec[NITRIG+2] = ch_filt_i[1];
    assign src_vec[NITRIG+3] = ext_trig_i;

    always_comb begin
        use_src_o = mode_uses_src(slv_mode_i);
        src_lvl_o = src_vec[trig_sel_i];
    end
endmodule

// File: rtl/tmr_edge_det.sv
module tmr_edge_det
    import tmr_presc_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic lvl_i,
    output logic rise_o
);
    edge_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.prev = lvl_i;
        rise_o    = lvl_i & ~st_q.prev;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    // R5
    rise_then_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rise_o |=> st_q.prev);
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int unsigned PSC_W = 16
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             en_i,
    input  logic             evt_i,
    input  logic [PSC_W-1:0] psc_val_i,
    output logic             tick_o
);
    typedef struct packed {
        logic [PSC_W-1:0] cnt;
        logic [PSC_W-1:0] ratio;
        logic             tick;
    } psc_state_t;

    psc_state_t st_d, st_q;
    logic       wrap;

    always_comb begin
        st_d      = st_q;
        st_d.tick = 1'b0;
        wrap      = en_i && evt_i && (st_q.cnt == st_q.ratio);
        if (!en_i) begin
            st_d.cnt   = '0;
            st_d.ratio = psc_val_i;
        end else if (evt_i) begin
            if (wrap) begin
                st_d.cnt   = '0;
                st_d.ratio = psc_val_i;
                st_d.tick  = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign tick_o = st_q.tick;

    // R6
    cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.cnt <= st_q.ratio);
    // R7
    ratio_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i && (st_q.cnt != st_q.ratio)) |=> $stable(st_q.ratio));
    // R6
    cnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (en_i && !evt_i) |=> $stable(st_q.cnt));
    // R8
    no_tick_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |=> (!tick_o && st_q.cnt == '0));
endmodule

// File: rtl/tmr_clk_presc.sv
module tmr_clk_presc
    import tmr_presc_pkg::*;
#(
    parameter int unsigned PSC_W  = 16,
    parameter int unsigned NITRIG = 4
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [2:0]        slv_mode_i,
    input  logic [2:0]        trig_sel_i,
    input  logic [NITRIG-1:0] itrig_i,
    input  logic              ch0_edge_i,
    input  logic [1:0]        ch_filt_i,
    input  logic              ext_trig_i,
    input  logic              cnt_en_i,
    input  logic [PSC_W-1:0]  psc_val_i,
    output logic              tick_o
);
    logic use_src, src_lvl, src_rise, evt;

    tmr_src_sel #(.NITRIG(NITRIG)) u_sel (
        .slv_mode_i (slv_mode_i),
        .trig_sel_i (trig_sel_i),
        .itrig_i    (itrig_i),
        .ch0_edge_i (ch0_edge_i),
        .ch_filt_i  (ch_filt_i),
        .ext_trig_i (ext_trig_i),
        .use_src_o  (use_src),
        .src_lvl_o  (src_lvl)
    );

    tmr_edge_det u_edge (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .lvl_i  (src_lvl),
        .rise_o (src_rise)
    );

    // R2 / R3: internal clock gives an event every cycle
    assign evt = use_src ? src_rise : 1'b1;

    tmr_prescaler #(.PSC_W(PSC_W)) u_psc (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .en_i      (cnt_en_i),
        .evt_i     (evt),
        .psc_val_i (psc_val_i),
        .tick_o    (tick_o)
    );
endmodule

// File: tb/tb_tmr_clk_presc.sv
module tb_tmr_clk_presc;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  mode, sel;
    logic [7:0]  srcv;
    logic        en;
    logic [15:0] psc;
    logic        tick;

    int n_chk = 0, n_fail = 0, tick_cnt = 0;
    bit done = 1'b0;
    bit prev_tick = 1'b0;
    int dbl = 0;

    always #(CLK_P/2) clk = ~clk;

    tmr_clk_presc dut (
        .clk_i(clk), .rst_ni(rst_n), .slv_mode_i(mode), .trig_sel_i(sel),
        .itrig_i(srcv[3:0]), .ch0_edge_i(srcv[4]), .ch_filt_i(srcv[6:5]),
        .ext_trig_i(srcv[7]), .cnt_en_i(en), .psc_val_i(psc), .tick_o(tick)
    );

    always @(negedge clk) begin
        if (tick) tick_cnt++;
        if (tick && prev_tick && psc != 0) dbl++;
        prev_tick = tick;
    end

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit ext_mode(input logic [2:0] m);
        return (m == 3'd1 || m == 3'd2 || m == 3'd3 || m == 3'd7);
    endfunction

    task automatic setup(input logic [2:0] m, input logic [2:0] s, input int p);
        @(negedge clk);
        en = 1'b0; mode = m; sel = s; psc = 16'(p); srcv = '0;
        repeat (3) @(negedge clk);
        tick_cnt = 0;
    endtask

    task automatic drain();
        en = 1'b0; srcv = '0;
        repeat (2) @(negedge clk);
    endtask

    task automatic run_case(input logic [2:0] m, input logic [2:0] s, input int p);
        int exp;
        setup(m, s, p);
        en = 1'b1;
        if (!ext_mode(m)) begin
            // R2: noise on every source line, each cycle is an event
            for (int i = 0; i < 10; i++) begin
                srcv = 8'(i * 37 + 5);
                @(negedge clk);
            end
            exp = 10 / (p + 1);
        end else begin
            // R3 R4 R5: selected line pulses, other lines toggle
            for (int e = 0; e < 7; e++) begin
                srcv = (8'(e * 91) & ~(8'd1 << s)) | (8'd1 << s);
                @(negedge clk);
                if (e % 2 == 1) begin
                    srcv = (8'(e * 53) & ~(8'd1 << s)) | (8'd1 << s);
                    @(negedge clk);
                end
                srcv = 8'(e * 29 + 3) & ~(8'd1 << s);
                @(negedge clk);
            end
            exp = 7 / (p + 1);
        end
        drain();
        // R6 R9 (value set while disabled)
        check($sformatf("R6 mode=%0d sel=%0d p=%0d", m, s, p), tick_cnt, exp);
    endtask

    initial begin
        mode = '0; sel = '0; srcv = '0; en = 1'b0; psc = '0;
        repeat (3) @(negedge clk);
        check("R1 tick after reset", int'(tick), 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check("R1 no tick while disabled", tick_cnt, 0);

        for (int m = 0; m < 8; m++)
            for (int s = 0; s < 8; s++)
                for (int p = 0; p < 4; p++)
                    run_case(3'(m), 3'(s), p);
        check("R6 single-cycle tick", dbl, 0);

        // R7: change value mid period
        setup(3'd0, 3'd0, 3);
        en = 1'b1;
        repeat (2) @(negedge clk);
        psc = 16'd1;
        repeat (8) @(negedge clk);
        drain();
        check("R7 reload at wrap", tick_cnt, 4);

        // R8: disable clears count
        setup(3'd0, 3'd0, 3);
        en = 1'b1;
        repeat (2) @(negedge clk);
        en = 1'b0;
        repeat (3) @(negedge clk);
        check("R8 no tick while off", tick_cnt, 0);
        en = 1'b1;
        repeat (3) @(negedge clk);
        drain();
        check("R8 count restarted", tick_cnt, 0);

        // R6: larger ratio
        setup(3'd4, 3'd0, 300);
        en = 1'b1;
        repeat (602) @(negedge clk);
        drain();
        check("R6 ratio 301", tick_cnt, 2);

        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule